// File: doc/BRIEF.md
# Dual DAC Reference Word Sequencer

This block loads a fixed-length list of 16-bit reference words from a small word memory and sends each one to one of two serial DACs over a shared clock and data line. Each DAC has its own active-low chip select. The words are sent exactly as stored, most significant bit first, so the top nibble reaches the DAC as its command code without any change. Consecutive words form pairs. The first word of a pair goes to device A and the second goes to device B. The list is sent strictly in memory order because each DAC applies its updates in the order it receives them.

A one-cycle `start` pulse begins a full update. The block does not lock the memory, so words may change between updates. Each word is fetched only when it is needed. The fetch uses a request/acknowledge handshake: `mem_req` and `mem_addr` stay steady until the memory raises `mem_ack` together with valid `mem_rdata`. The memory may stall for any number of cycles, and the serial link waits while it does. The sequencer never stalls the memory. When the last word has been sent and the idle gap after it has elapsed, `done` pulses for one cycle.

The serial clock idles low. Data changes on the falling edge of `sck` and the DAC samples it on the rising edge. `N_WORDS` must be even. `SCK_PERIOD` must be even and at least 2. `IDLE_GAP` must be at least 1.

Top module: `dacseq_top`

## Requirements
- R1: During and after a synchronous active-high reset, both chip selects are high, `sck` is low, and `mem_req`, `busy` and `done` are low.
- R2: A `start` pulse while idle raises `busy` and fetches the words at addresses `BASE_ADDR` to `BASE_ADDR+N_WORDS-1`, one at a time, in increasing order.
- R3: While `mem_req` is high and `mem_ack` is low, `mem_req` and `mem_addr` stay unchanged. `mem_rdata` is read only in the cycle in which `mem_ack` is high, and any stall length is accepted.
- R4: Each word is sent as all 16 of its bits unchanged, bit 15 first. Bits 15:12 are the DAC command code and are sent as stored.
- R5: Word k of the list goes to `cs_n[0]` (device A) when k is even and to `cs_n[1]` (device B) when k is odd. Both selects are never low at the same time.
- R6: For each word, the chosen select stays low for exactly 16*`SCK_PERIOD` clock cycles and contains exactly 16 rising edges of `sck`. `sck` is low whenever both selects are high.
- R7: While a select is low, `mosi` changes only together with a falling edge of `sck`, so it is stable across every rising edge.
- R8: Between two consecutive words, both selects stay high for at least `IDLE_GAP` clock cycles.
- R9: After the last word, `done` is high for exactly one cycle, and in that cycle `busy` is already low.
- R10: A `start` pulse while `busy` is high is ignored: the update in progress is not restarted, and no additional words are sent afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a full update |
| busy | output | 1 | High from the cycle after an accepted start until `done` |
| done | output | 1 | One-cycle pulse when an update is finished |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | ADDR_W | Address of the requested word |
| mem_ack | input | 1 | Memory acknowledge; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 16 | Fetched reference word |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to both DACs |
| cs_n | output | 2 | Active-low chip selects: bit 0 for device A, bit 1 for device B |

## Verification
The bench builds the block with `N_WORDS=4`, `SCK_PERIOD=6`, `IDLE_GAP=3`, `BASE_ADDR=5` and `ADDR_W=6`. These values give two full A/B pairs per update and an `sck` period of three high and three low clocks, so off-by-one errors in the select window or the edge position are visible. The non-zero base address tests that address offsetting is applied. The memory model varies its stall from zero to three cycles between fetches, which tests both the back-pressure path and the zero-wait path within each update.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
  localparam int WORD_BITS = 16;
  localparam int BIT_W     = $clog2(WORD_BITS);

  typedef logic [WORD_BITS-1:0] dac_word_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/dacseq_sclk.sv
// Serial clock phase generator: low half first, then high half.
// bit_tick marks the last clock of each period (the falling edge follows).
module dacseq_sclk #(
  parameter int SCK_PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic bit_tick
);
  localparam int CNT_W = (SCK_PERIOD > 2) ? $clog2(SCK_PERIOD) : 1;
  localparam int HALF  = SCK_PERIOD / 2;

  logic [CNT_W-1:0] phase_q;
  logic             wrap;

  assign wrap = (phase_q == CNT_W'(SCK_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= '0;
    end else if (wrap) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + CNT_W'(1);
    end
  end

  assign sck      = run && (phase_q >= CNT_W'(HALF));
  assign bit_tick = run && wrap;
endmodule

// File: rtl/dacseq_shreg.sv
// Word shift register: loads a whole word and presents bit 15 first.
module dacseq_shreg
  import dacseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  dac_word_t load_word,
  input  logic      shift,
  output logic      mosi,
  output logic      last_bit
);
  dac_word_t        sr_q;
  logic [BIT_W-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      bit_q <= '0;
    end else if (load) begin
      sr_q  <= load_word;
      bit_q <= '0;
    end else if (shift) begin
      sr_q  <= {sr_q[WORD_BITS-2:0], 1'b0};
      bit_q <= bit_q + BIT_W'(1);
    end
  end

  assign mosi     = sr_q[WORD_BITS-1];
  assign last_bit = (bit_q == BIT_W'(WORD_BITS - 1));
endmodule

// File: rtl/dacseq_ctrl.sv
// Update sequencer: fetch, shift, gap, for every list entry in order.
module dacseq_ctrl
  import dacseq_pkg::*;
#(
  parameter int N_WORDS   = 8,
  parameter int IDLE_GAP  = 2,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mem_ack,
  input  logic              bit_tick,
  input  logic              last_bit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              load,
  output logic              shift_run,
  output logic [1:0]        cs_n,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W = (N_WORDS > 2) ? $clog2(N_WORDS) : 1;
  localparam int GAP_W = $clog2(IDLE_GAP + 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [GAP_W-1:0] gap_q;
  logic [1:0]       cs_n_q;
  logic             done_q;
  logic             last_idx;
  logic             gap_end;
  logic [1:0]       sel_n;

  assign last_idx = (idx_q == IDX_W'(N_WORDS - 1));
  assign gap_end  = (gap_q == GAP_W'(IDLE_GAP - 1));

  // Device choice per list position: even -> A (bit 0), odd -> B (bit 1).
  for (genvar d = 0; d < 2; d++) begin : g_sel
    assign sel_n[d] = (idx_q[0] != d[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      gap_q   <= '0;
      cs_n_q  <= 2'b11;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_FETCH;
            idx_q   <= '0;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            state_q <= ST_SHIFT;
            cs_n_q  <= sel_n;
          end
        end
        ST_SHIFT: begin
          if (bit_tick && last_bit) begin
            state_q <= ST_GAP;
            cs_n_q  <= 2'b11;
            gap_q   <= '0;
          end
        end
        ST_GAP: begin
          if (gap_end) begin
            if (last_idx) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_FETCH;
              idx_q   <= idx_q + IDX_W'(1);
            end
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q == ST_FETCH);
  assign mem_addr  = ADDR_W'(BASE_ADDR) + ADDR_W'(idx_q);
  assign load      = mem_req && mem_ack;
  assign shift_run = (state_q == ST_SHIFT);
  assign cs_n      = cs_n_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
endmodule

// File: rtl/dacseq_top.sv
module dacseq_top
  import dacseq_pkg::*;
#(
  parameter int N_WORDS    = 8,
  parameter int SCK_PERIOD = 4,
  parameter int IDLE_GAP   = 2,
  parameter int ADDR_W     = 8,
  parameter int BASE_ADDR  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic              sck,
  output logic              mosi,
  output logic [1:0]        cs_n
);
  logic load;
  logic shift_run;
  logic bit_tick;
  logic last_bit;

  dacseq_ctrl #(
    .N_WORDS  (N_WORDS),
    .IDLE_GAP (IDLE_GAP),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mem_ack  (mem_ack),
    .bit_tick (bit_tick),
    .last_bit (last_bit),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .load     (load),
    .shift_run(shift_run),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done)
  );

  dacseq_sclk #(
    .SCK_PERIOD(SCK_PERIOD)
  ) sclk_i (
    .clk     (clk),
    .rst     (rst),
    .run     (shift_run),
    .sck     (sck),
    .bit_tick(bit_tick)
  );

  dacseq_shreg shreg_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_word(dac_word_t'(mem_rdata)),
    .shift    (bit_tick),
    .mosi     (mosi),
    .last_bit (last_bit)
  );
endmodule

// File: rtl/dacseq_chk.sv
module dacseq_chk #(
  parameter int SCK_PERIOD = 4,
  parameter int IDLE_GAP   = 2,
  parameter int ADDR_W     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              sck,
  input logic              mosi,
  input logic [1:0]        cs_n
);
  int   lo_cnt;
  int   hi_cnt;
  logic seen_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt    <= 0;
      hi_cnt    <= 0;
      seen_word <= 1'b0;
    end else if (cs_n != 2'b11) begin
      lo_cnt    <= lo_cnt + 1;
      hi_cnt    <= 0;
      seen_word <= 1'b1;
    end else begin
      lo_cnt <= 0;
      if (hi_cnt < IDLE_GAP + 1) hi_cnt <= hi_cnt + 1;
    end
  end

  // R5
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n != 2'b00);

  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n == 2'b11) |-> !sck);

  // R6
  window_len_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n == 2'b11 && $past(cs_n) != 2'b11) |-> (lo_cnt == 16 * SCK_PERIOD));

  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n != 2'b11 && cs_n == $past(cs_n) && !$fell(sck)) |-> $stable(mosi));

  // R8
  gap_len_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_word && cs_n != 2'b11 && $past(cs_n) == 2'b11) |-> (hi_cnt >= IDLE_GAP));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind dacseq_top dacseq_chk #(
  .SCK_PERIOD(SCK_PERIOD),
  .IDLE_GAP  (IDLE_GAP),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .mem_req (mem_req),
  .mem_ack (mem_ack),
  .mem_addr(mem_addr),
  .sck     (sck),
  .mosi    (mosi),
  .cs_n    (cs_n)
);

// File: tb/dacseq_top_tb_top.sv
`timescale 1ns/1ps
module dacseq_top_tb_top;
  localparam int N_WORDS    = 4;
  localparam int SCK_PERIOD = 6;
  localparam int IDLE_GAP   = 3;
  localparam int ADDR_W     = 6;
  localparam int BASE_ADDR  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              busy, done, mem_req, sck, mosi;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ack = 1'b0;
  logic [15:0]       mem_rdata = 16'hDEAD;
  logic [1:0]        cs_n;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int words_seen = 0;
  bit finished = 1'b0;

  logic [15:0] mem [0:(1<<ADDR_W)-1];
  logic [16:0] exp_q [$];
  int          exp_addr = BASE_ADDR;

  always #2.5 clk = ~clk;

  dacseq_top #(
    .N_WORDS   (N_WORDS),
    .SCK_PERIOD(SCK_PERIOD),
    .IDLE_GAP  (IDLE_GAP),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .sck      (sck),
    .mosi     (mosi),
    .cs_n     (cs_n)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory responder: stall 0..3 cycles, garbage on data outside ack (R3).
  initial begin
    int lat = 0;
    int waited = 0;
    logic [ADDR_W-1:0] held;
    forever begin
      @(negedge clk);
      mem_ack   = 1'b0;
      mem_rdata = 16'hDEAD;
      if (mem_req) begin
        if (waited > 0) check(mem_addr == held, "R3 addr held", mem_addr, held);
        held = mem_addr;
        if (waited >= lat) begin
          check(mem_addr == ADDR_W'(exp_addr), "R2 fetch order", mem_addr, exp_addr);
          mem_ack   = 1'b1;
          mem_rdata = mem[mem_addr];
          exp_addr++;
          waited = 0;
          lat = (lat + 1) % 4;
        end else begin
          waited++;
        end
      end
    end
  end

  // Monitor: rebuilds each word from the serial lines and scores it.
  initial begin
    logic        psck = 1'b0;
    logic        pmosi = 1'b0;
    logic [1:0]  pcs = 2'b11;
    logic [15:0] cap = '0;
    int          bits = 0;
    int          lowcyc = 0;
    int          hicyc = 0;
    bit          had_word = 1'b0;
    logic [16:0] exp;
    forever begin
      @(negedge clk);
      if (rst) begin
        psck = 1'b0; pcs = 2'b11; pmosi = mosi;
        continue;
      end
      if (done) begin
        done_cnt++;
        check(!busy, "R9 busy low with done", busy, 0);
      end
      if (cs_n == 2'b00) check(1'b0, "R5 both selects low", cs_n, 2'b10);
      if (cs_n != 2'b11) begin
        if (pcs == 2'b11) begin
          if (had_word) check(hicyc >= IDLE_GAP, "R8 gap length", hicyc, IDLE_GAP);
          bits = 0; lowcyc = 0; cap = '0;
        end else begin
          if (cs_n != pcs) check(1'b0, "R5 select switched mid word", cs_n, pcs);
          if (sck && psck && mosi != pmosi) check(1'b0, "R7 mosi moved while sck high", mosi, pmosi);
        end
        lowcyc++;
        if (sck && !psck) begin
          bits++;
          cap = {cap[14:0], mosi};
        end
      end else begin
        if (sck) check(1'b0, "R6 sck high while deselected", sck, 0);
        if (pcs != 2'b11) begin
          words_seen++;
          had_word = 1'b1;
          hicyc = 0;
          check(lowcyc == 16 * SCK_PERIOD, "R6 select window length", lowcyc, 16 * SCK_PERIOD);
          check(bits == 16, "R6 rising edge count", bits, 16);
          if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected extra word", {pcs[1], cap}, 0);
          end else begin
            exp = exp_q.pop_front();
            check(cap == exp[15:0], "R4 word verbatim MSB first", cap, exp[15:0]);
            check(cap[15:12] == exp[15:12], "R4 command nibble", cap[15:12], exp[15:12]);
            check(pcs == (exp[16] ? 2'b01 : 2'b10), "R5 device by list position", pcs, exp[16] ? 2'b01 : 2'b10);
          end
        end
        hicyc++;
      end
      psck = sck; pmosi = mosi; pcs = cs_n;
    end
  end

  task automatic run_update(input logic [15:0] w0, input logic [15:0] w1,
                            input logic [15:0] w2, input logic [15:0] w3,
                            input bit poke_busy);
    int d0 = done_cnt;
    int s0 = words_seen;
    mem[BASE_ADDR + 0] = w0;
    mem[BASE_ADDR + 1] = w1;
    mem[BASE_ADDR + 2] = w2;
    mem[BASE_ADDR + 3] = w3;
    for (int k = 0; k < N_WORDS; k++) exp_q.push_back({1'(k % 2), mem[BASE_ADDR + k]});
    exp_addr = BASE_ADDR;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy, "R2 busy after start", busy, 1);
    if (poke_busy) begin
      while (words_seen == s0) @(negedge clk);
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy, "R10 still busy after ignored start", busy, 1);
    end
    while (done_cnt == d0 && !finished) @(negedge clk);
    repeat (300) @(negedge clk);
    check(done_cnt == d0 + 1, "R9 one done per update", done_cnt, d0 + 1);
    check(words_seen == s0 + N_WORDS, "R10 word count per update", words_seen - s0, N_WORDS);
    check(exp_q.size() == 0, "R2 all expected words sent", exp_q.size(), 0);
    check(!busy && cs_n == 2'b11, "R9 idle after update", {busy, cs_n}, 3'b011);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(cs_n == 2'b11 && !sck && !mem_req && !busy && !done, "R1 state in reset",
          {cs_n, sck, mem_req, busy, done}, 6'b110000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n == 2'b11 && !sck && !mem_req && !busy && !done, "R1 state after reset",
          {cs_n, sck, mem_req, busy, done}, 6'b110000);
    run_update(16'h1234, 16'hABCD, 16'h8001, 16'h7FFE, 1'b0);
    run_update(16'h0000, 16'hFFFF, 16'hF000, 16'h000F, 1'b0);
    run_update(16'h5A5A, 16'hA5A5, 16'h3C3C, 16'hC3C3, 1'b1);
    run_update(16'h9AC3, 16'h2B71, 16'hE00E, 16'h4C5D, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule